// File: doc/BRIEF.md
# Write-Pending Register Scoreboard

This block records, with one bit per architectural register, which registers still wait for a result. Issue logic marks destinations as pending through several independent set ports. An instruction with two destinations, such as a load with base-address update, uses two set ports in the same cycle. Functional units return their results through per-unit result slots. Slot k of every unit competes for write port k, and a fixed-priority picker on each port grants one unit per cycle. A granted write clears its register's pending bit.

A unit may decide at completion that it will not write a destination it announced. It then presents that slot with its data-valid flag low. The block accepts such a slot at once, raises no write-port request for it, and clears the pending bit. This way the bit is not left set while waiting for a write that never comes. A combinational hazard output tells issue logic whether any source operand or the destination of the next instruction is still pending.

Each result slot is a valid/ready stream. A slot is valid when its unit's `fu_done` and the slot's `fu_mask` bit are both high. The unit holds `fu_mask`, `fu_ok` and `fu_addr` of a valid slot steady until the cycle in which the slot's `fu_ready` is high. It may clear that mask bit in the following cycle. A valid slot may not be withdrawn before its ready. Set ports and the hazard lookup are plain control pins with no handshake.

Top module: `wr_pend_scoreboard`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears every pending bit, so `pend_o` reads all zero on the cycle after reset.
- R2: A set port with its enable high makes the addressed bit of `pend_o` high on the next cycle. All set ports are ORed, so two ports naming the same register act as one request.
- R3: Two set ports naming different registers in one cycle make both registers pending on the next cycle.
- R4: Slot k of unit u (flat index u*WR_PORTS+k) requests write port k only when `fu_done[u]`, `fu_mask` and `fu_ok` of that slot are all high. Among requesters, the lowest unit index is granted. Each port grants at most one slot per cycle. A slot that is not valid never sees `fu_ready` high.
- R5: In the grant cycle, `wp_valid[k]` is high and `wp_addr` field k carries the granted slot's register address. The granted slot's `fu_ready` is high in that same cycle, and the register's pending bit is low on the next cycle.
- R6: A valid slot with `fu_ok` low is a dropped write. Its `fu_ready` is high in the same cycle, it raises no write-port activity, and its register's pending bit is low on the next cycle.
- R7: When a set and a clear (grant or drop) name the same register in one cycle, the set wins and the bit is high on the next cycle.
- R8: A dropped write and a granted write naming the same register in one cycle together clear the bit once. The bit is low on the next cycle, and both slots see ready.
- R9: `hazard` is high in the same cycle, with no register stage, when any enabled source address or the enabled destination address names a pending register. Otherwise it is low.
- R10: A requesting slot that loses arbitration sees `fu_ready` low, and its register stays pending until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_en | input | SET_PORTS | Per set port: mark the addressed register pending |
| set_addr | input | SET_PORTS*AW | Register address of each set port, port i in bits [i*AW +: AW] |
| fu_done | input | UNITS | Per unit: its result slots are presented this cycle |
| fu_mask | input | UNITS*WR_PORTS | Per slot: the destination was announced at issue |
| fu_ok | input | UNITS*WR_PORTS | Per slot: data was produced (high) or the write is dropped (low) |
| fu_addr | input | UNITS*WR_PORTS*AW | Per slot destination register address |
| fu_ready | output | UNITS*WR_PORTS | Per slot: accepted this cycle (granted or dropped) |
| wp_valid | output | WR_PORTS | Per write port: a granted write is on the port |
| wp_addr | output | WR_PORTS*AW | Per write port: register address of the granted write |
| src_en | input | SRC_PORTS | Per source operand: lookup enabled |
| src_addr | input | SRC_PORTS*AW | Source operand register addresses |
| dst_en | input | 1 | Destination lookup enabled |
| dst_addr | input | AW | Destination register address |
| hazard | output | 1 | Some enabled looked-up register is pending |
| pend_o | output | NUM_REGS | Pending vector, one bit per register |

## Verification
The assertions assume that issue logic never sets a register that is already pending, unless that register is being cleared in the same cycle. They also assume that each valid slot names a register that is pending, owned by that slot alone, and held steady until ready. The one allowed exception is the deliberate drop-plus-grant collision. The random stimulus keeps an ownership table in the bench. A unit may only claim pending registers no other slot owns, and a set port only targets a free register or one that is being released in that cycle. Directed cases then step outside the single-owner rule once, to cover the double-clear collision.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Classification of one result slot in the current cycle.
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_WRITE = 2'd1,
    SLOT_DROP  = 2'd2
  } slot_kind_e;

endpackage

// File: rtl/sb_picker.sv
// Fixed-priority picker: lowest requesting index wins.
module sb_picker #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign gnt[i]      = req[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req[i];
  end

endmodule

// File: rtl/sb_slot_decode.sv
// Splits each result slot into write request, drop, or idle.
module sb_slot_decode import sb_pkg::*; #(
  parameter int UNITS    = 3,
  parameter int WR_PORTS = 2,
  localparam int SLOTS   = UNITS * WR_PORTS
) (
  input  logic [UNITS-1:0] fu_done,
  input  logic [SLOTS-1:0] fu_mask,
  input  logic [SLOTS-1:0] fu_ok,
  output logic [SLOTS-1:0] wr_req,
  output logic [SLOTS-1:0] drop
);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    for (genvar k = 0; k < WR_PORTS; k++) begin : g_slot
      localparam int S = u * WR_PORTS + k;
      slot_kind_e kind;

      always_comb begin
        if (!(fu_done[u] && fu_mask[S])) kind = SLOT_IDLE;
        else if (fu_ok[S])               kind = SLOT_WRITE;
        else                             kind = SLOT_DROP;
      end

      assign wr_req[S] = (kind == SLOT_WRITE);
      assign drop[S]   = (kind == SLOT_DROP);
    end
  end

endmodule

// File: rtl/sb_port_arb.sv
// One write port: picks a requesting unit and steers its address.
module sb_port_arb #(
  parameter int UNITS = 3,
  parameter int AW    = 5
) (
  input  logic [UNITS-1:0]    req,
  input  logic [UNITS*AW-1:0] req_addr,
  output logic [UNITS-1:0]    gnt,
  output logic                port_valid,
  output logic [AW-1:0]       port_addr
);

  sb_picker #(.N(UNITS)) picker_i (
    .req (req),
    .gnt (gnt)
  );

  always_comb begin
    port_addr = '0;
    for (int u = 0; u < UNITS; u++) begin
      if (gnt[u]) port_addr = port_addr | req_addr[u*AW +: AW];
    end
  end

  assign port_valid = |req;

endmodule

// File: rtl/sb_pend_vec.sv
// Pending-bit vector: decoded sets and clears, set wins on collision.
module sb_pend_vec #(
  parameter int NUM_REGS  = 32,
  parameter int SET_PORTS = 2,
  parameter int CLR_PORTS = 8,
  parameter int AW        = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SET_PORTS-1:0]    set_en,
  input  logic [SET_PORTS*AW-1:0] set_addr,
  input  logic [CLR_PORTS-1:0]    clr_en,
  input  logic [CLR_PORTS*AW-1:0] clr_addr,
  output logic [NUM_REGS-1:0]     pend
);

  logic [NUM_REGS-1:0] set_m;
  logic [NUM_REGS-1:0] clr_m;

  always_comb begin
    set_m = '0;
    for (int i = 0; i < SET_PORTS; i++) begin
      if (set_en[i]) set_m[set_addr[i*AW +: AW]] = 1'b1;
    end
  end

  always_comb begin
    clr_m = '0;
    for (int i = 0; i < CLR_PORTS; i++) begin
      if (clr_en[i]) clr_m[clr_addr[i*AW +: AW]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_m) | set_m;
  end

endmodule

// File: rtl/sb_hazard.sv
// Combinational lookup of several register addresses in the pending vector.
module sb_hazard #(
  parameter int NUM_REGS = 32,
  parameter int PORTS    = 4,
  parameter int AW       = 5
) (
  input  logic [NUM_REGS-1:0] pend,
  input  logic [PORTS-1:0]    look_en,
  input  logic [PORTS*AW-1:0] look_addr,
  output logic                hit
);

  logic [PORTS-1:0] hit_v;

  for (genvar i = 0; i < PORTS; i++) begin : g_look
    assign hit_v[i] = look_en[i] & pend[look_addr[i*AW +: AW]];
  end

  assign hit = |hit_v;

endmodule

// File: rtl/wr_pend_scoreboard.sv
module wr_pend_scoreboard #(
  parameter int NUM_REGS  = 32,
  parameter int SET_PORTS = 2,
  parameter int WR_PORTS  = 2,
  parameter int UNITS     = 3,
  parameter int SRC_PORTS = 3,
  localparam int AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [SET_PORTS-1:0]             set_en,
  input  logic [SET_PORTS*AW-1:0]          set_addr,
  input  logic [UNITS-1:0]                 fu_done,
  input  logic [UNITS*WR_PORTS-1:0]        fu_mask,
  input  logic [UNITS*WR_PORTS-1:0]        fu_ok,
  input  logic [UNITS*WR_PORTS*AW-1:0]     fu_addr,
  output logic [UNITS*WR_PORTS-1:0]        fu_ready,
  output logic [WR_PORTS-1:0]              wp_valid,
  output logic [WR_PORTS*AW-1:0]           wp_addr,
  input  logic [SRC_PORTS-1:0]             src_en,
  input  logic [SRC_PORTS*AW-1:0]          src_addr,
  input  logic                             dst_en,
  input  logic [AW-1:0]                    dst_addr,
  output logic                             hazard,
  output logic [NUM_REGS-1:0]              pend_o
);

  localparam int SLOTS     = UNITS * WR_PORTS;
  localparam int CLR_PORTS = SLOTS + WR_PORTS;
  localparam int LOOKS     = SRC_PORTS + 1;

  logic [SLOTS-1:0] wr_req;
  logic [SLOTS-1:0] drop;
  logic [SLOTS-1:0] gnt_flat;

  sb_slot_decode #(
    .UNITS    (UNITS),
    .WR_PORTS (WR_PORTS)
  ) decode_i (
    .fu_done (fu_done),
    .fu_mask (fu_mask),
    .fu_ok   (fu_ok),
    .wr_req  (wr_req),
    .drop    (drop)
  );

  // Slot k of every unit competes for write port k.
  for (genvar k = 0; k < WR_PORTS; k++) begin : g_port
    logic [UNITS-1:0]    req_k;
    logic [UNITS*AW-1:0] addr_k;
    logic [UNITS-1:0]    gnt_k;

    for (genvar u = 0; u < UNITS; u++) begin : g_gather
      assign req_k[u]                = wr_req[u*WR_PORTS + k];
      assign addr_k[u*AW +: AW]      = fu_addr[(u*WR_PORTS + k)*AW +: AW];
      assign gnt_flat[u*WR_PORTS + k] = gnt_k[u];
    end

    sb_port_arb #(
      .UNITS (UNITS),
      .AW    (AW)
    ) arb_i (
      .req        (req_k),
      .req_addr   (addr_k),
      .gnt        (gnt_k),
      .port_valid (wp_valid[k]),
      .port_addr  (wp_addr[k*AW +: AW])
    );
  end

  assign fu_ready = gnt_flat | drop;

  // Clear sources: every granted write port, plus every dropped slot.
  logic [CLR_PORTS-1:0]    clr_en;
  logic [CLR_PORTS*AW-1:0] clr_addr;

  assign clr_en   = {wp_valid, drop};
  assign clr_addr = {wp_addr, fu_addr};

  sb_pend_vec #(
    .NUM_REGS  (NUM_REGS),
    .SET_PORTS (SET_PORTS),
    .CLR_PORTS (CLR_PORTS),
    .AW        (AW)
  ) vec_i (
    .clk      (clk),
    .rst      (rst),
    .set_en   (set_en),
    .set_addr (set_addr),
    .clr_en   (clr_en),
    .clr_addr (clr_addr),
    .pend     (pend_o)
  );

  sb_hazard #(
    .NUM_REGS (NUM_REGS),
    .PORTS    (LOOKS),
    .AW       (AW)
  ) haz_i (
    .pend      (pend_o),
    .look_en   ({dst_en, src_en}),
    .look_addr ({dst_addr, src_addr}),
    .hit       (hazard)
  );

endmodule

// File: rtl/wr_pend_scoreboard_chk.sv
module wr_pend_scoreboard_chk #(
  parameter int NUM_REGS  = 32,
  parameter int SET_PORTS = 2,
  parameter int WR_PORTS  = 2,
  parameter int UNITS     = 3,
  parameter int SRC_PORTS = 3,
  localparam int AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic [SET_PORTS-1:0]         set_en,
  input logic [SET_PORTS*AW-1:0]      set_addr,
  input logic [UNITS-1:0]             fu_done,
  input logic [UNITS*WR_PORTS-1:0]    fu_mask,
  input logic [UNITS*WR_PORTS-1:0]    fu_ok,
  input logic [UNITS*WR_PORTS*AW-1:0] fu_addr,
  input logic [UNITS*WR_PORTS-1:0]    fu_ready,
  input logic [WR_PORTS-1:0]          wp_valid,
  input logic [WR_PORTS*AW-1:0]       wp_addr,
  input logic [SRC_PORTS-1:0]         src_en,
  input logic [SRC_PORTS*AW-1:0]      src_addr,
  input logic                         dst_en,
  input logic [AW-1:0]                dst_addr,
  input logic                         hazard,
  input logic [NUM_REGS-1:0]          pend_o
);

  logic [NUM_REGS-1:0] set_hit;

  always_comb begin
    set_hit = '0;
    for (int i = 0; i < SET_PORTS; i++) begin
      if (set_en[i]) set_hit[set_addr[i*AW +: AW]] = 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> pend_o == '0);

  for (genvar i = 0; i < SET_PORTS; i++) begin : g_set
    p_set_visible_r2: assert property (@(posedge clk) disable iff (rst)
      set_en[i] |=> pend_o[$past(set_addr[i*AW +: AW])]);
  end

  for (genvar k = 0; k < WR_PORTS; k++) begin : g_port
    logic [UNITS-1:0] won;
    for (genvar u = 0; u < UNITS; u++) begin : g_won
      localparam int S = u * WR_PORTS + k;
      assign won[u] = fu_ready[S] & fu_done[u] & fu_mask[S] & fu_ok[S];
    end

    p_one_grant_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(won));

    p_port_matches_r5: assert property (@(posedge clk) disable iff (rst)
      wp_valid[k] == (|won));

    p_grant_clears_r5: assert property (@(posedge clk) disable iff (rst)
      (wp_valid[k] && !set_hit[wp_addr[k*AW +: AW]])
      |=> !pend_o[$past(wp_addr[k*AW +: AW])]);
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    for (genvar k = 0; k < WR_PORTS; k++) begin : g_slot
      localparam int S = u * WR_PORTS + k;

      p_idle_not_ready_r4: assert property (@(posedge clk) disable iff (rst)
        !(fu_done[u] && fu_mask[S]) |-> !fu_ready[S]);

      p_drop_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (fu_done[u] && fu_mask[S] && !fu_ok[S]) |-> fu_ready[S]);

      p_drop_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (fu_done[u] && fu_mask[S] && !fu_ok[S] && !set_hit[fu_addr[S*AW +: AW]])
        |=> !pend_o[$past(fu_addr[S*AW +: AW])]);
    end
  end

  for (genvar j = 0; j < SRC_PORTS; j++) begin : g_src
    p_src_hazard_r9: assert property (@(posedge clk) disable iff (rst)
      (src_en[j] && pend_o[src_addr[j*AW +: AW]]) |-> hazard);
  end

  p_dst_hazard_r9: assert property (@(posedge clk) disable iff (rst)
    (dst_en && pend_o[dst_addr]) |-> hazard);

endmodule

bind wr_pend_scoreboard wr_pend_scoreboard_chk #(
  .NUM_REGS  (NUM_REGS),
  .SET_PORTS (SET_PORTS),
  .WR_PORTS  (WR_PORTS),
  .UNITS     (UNITS),
  .SRC_PORTS (SRC_PORTS)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .set_en   (set_en),
  .set_addr (set_addr),
  .fu_done  (fu_done),
  .fu_mask  (fu_mask),
  .fu_ok    (fu_ok),
  .fu_addr  (fu_addr),
  .fu_ready (fu_ready),
  .wp_valid (wp_valid),
  .wp_addr  (wp_addr),
  .src_en   (src_en),
  .src_addr (src_addr),
  .dst_en   (dst_en),
  .dst_addr (dst_addr),
  .hazard   (hazard),
  .pend_o   (pend_o)
);

// File: tb/wr_pend_scoreboard_tb_top.sv
module wr_pend_scoreboard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NR  = 32;
  localparam int SP  = 2;
  localparam int WP  = 2;
  localparam int NU  = 3;
  localparam int SRC = 3;
  localparam int AW  = 5;
  localparam int NS  = NU * WP;

  logic              clk = 1'b0;
  logic              rst;
  logic [SP-1:0]     set_en;
  logic [SP*AW-1:0]  set_addr;
  logic [NU-1:0]     fu_done;
  logic [NS-1:0]     fu_mask;
  logic [NS-1:0]     fu_ok;
  logic [NS*AW-1:0]  fu_addr;
  logic [NS-1:0]     fu_ready;
  logic [WP-1:0]     wp_valid;
  logic [WP*AW-1:0]  wp_addr;
  logic [SRC-1:0]    src_en;
  logic [SRC*AW-1:0] src_addr;
  logic              dst_en;
  logic [AW-1:0]     dst_addr;
  logic              hazard;
  logic [NR-1:0]     pend_o;

  logic [NR-1:0] ref_pend;
  logic [NR-1:0] owned;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_pend_scoreboard #(
    .NUM_REGS (NR), .SET_PORTS (SP), .WR_PORTS (WP), .UNITS (NU), .SRC_PORTS (SRC)
  ) dut_i (
    .clk (clk), .rst (rst), .set_en (set_en), .set_addr (set_addr),
    .fu_done (fu_done), .fu_mask (fu_mask), .fu_ok (fu_ok), .fu_addr (fu_addr),
    .fu_ready (fu_ready), .wp_valid (wp_valid), .wp_addr (wp_addr),
    .src_en (src_en), .src_addr (src_addr), .dst_en (dst_en), .dst_addr (dst_addr),
    .hazard (hazard), .pend_o (pend_o)
  );

  task automatic chk(input bit good, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected handshake results for the currently driven slots.
  task automatic predict(output logic [NS-1:0] e_rdy, output logic [WP-1:0] e_wv,
                         output logic [WP*AW-1:0] e_wa, output logic [NR-1:0] clr);
    e_rdy = '0; e_wv = '0; e_wa = '0; clr = '0;
    for (int k = 0; k < WP; k++) begin
      for (int u = 0; u < NU; u++) begin
        int s;
        logic [AW-1:0] a;
        s = u * WP + k;
        a = fu_addr[s*AW +: AW];
        if (fu_done[u] && fu_mask[s]) begin
          if (!fu_ok[s]) begin
            e_rdy[s] = 1'b1; clr[a] = 1'b1;
          end else if (!e_wv[k]) begin
            e_wv[k] = 1'b1; e_wa[k*AW +: AW] = a; e_rdy[s] = 1'b1; clr[a] = 1'b1;
          end
        end
      end
    end
  endtask

  // One cycle: check combinational outputs, clock, check the vector.
  task automatic step();
    logic [NS-1:0]    e_rdy;
    logic [WP-1:0]    e_wv;
    logic [WP*AW-1:0] e_wa;
    logic [NR-1:0]    clr, setm, nxt;
    logic             e_hz;
    #1;
    predict(e_rdy, e_wv, e_wa, clr);
    setm = '0;
    for (int i = 0; i < SP; i++) if (set_en[i]) setm[set_addr[i*AW +: AW]] = 1'b1;
    e_hz = dst_en && ref_pend[dst_addr];
    for (int j = 0; j < SRC; j++)
      if (src_en[j] && ref_pend[src_addr[j*AW +: AW]]) e_hz = 1'b1;
    chk(fu_ready == e_rdy, "R4 R6 R10 slot ready", 64'(fu_ready), 64'(e_rdy));
    chk(wp_valid == e_wv, "R4 R5 write port valid", 64'(wp_valid), 64'(e_wv));
    for (int k = 0; k < WP; k++)
      if (e_wv[k])
        chk(wp_addr[k*AW +: AW] == e_wa[k*AW +: AW], "R5 write port addr",
            64'(wp_addr[k*AW +: AW]), 64'(e_wa[k*AW +: AW]));
    chk(hazard == e_hz, "R9 hazard", 64'(hazard), 64'(e_hz));
    nxt = (ref_pend & ~clr) | setm;
    @(posedge clk);
    @(negedge clk);
    chk(pend_o == nxt, "R2 R3 R5 R6 R7 R8 pending vector", 64'(pend_o), 64'(nxt));
    ref_pend = nxt;
    for (int s = 0; s < NS; s++) begin
      if (e_rdy[s]) begin
        owned[fu_addr[s*AW +: AW]] = 1'b0;
        fu_mask[s] = 1'b0;
      end
    end
  endtask

  task automatic idle_inputs();
    set_en = '0; set_addr = '0; fu_done = '0; fu_mask = '0; fu_ok = '0;
    fu_addr = '0; src_en = '0; src_addr = '0; dst_en = 1'b0; dst_addr = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ref_pend = '0;
    owned = '0;
    chk(pend_o == '0, "R1 reset clears vector", 64'(pend_o), 64'd0);
  endtask

  task automatic set_slot(input int u, input int k, input bit ok, input int r);
    fu_mask[u*WP+k] = 1'b1;
    fu_ok[u*WP+k]   = ok;
    fu_addr[(u*WP+k)*AW +: AW] = AW'(r);
  endtask

  task automatic random_cycle();
    logic [NS-1:0]    e_rdy;
    logic [WP-1:0]    e_wv;
    logic [WP*AW-1:0] e_wa;
    logic [NR-1:0]    clr;
    set_en = '0;
    for (int u = 0; u < NU; u++) begin
      if (fu_mask[u*WP +: WP] == '0 && $urandom_range(2) == 0) begin
        for (int k = 0; k < WP; k++) begin
          int r;
          r = $urandom_range(NR-1);
          if (ref_pend[r] && !owned[r]) begin
            owned[r] = 1'b1;
            set_slot(u, k, ($urandom_range(3) != 0), r);
          end
        end
      end
      fu_done[u] = (fu_mask[u*WP +: WP] != '0) && ($urandom_range(2) != 0);
    end
    predict(e_rdy, e_wv, e_wa, clr);
    for (int i = 0; i < SP; i++) begin
      int r;
      r = $urandom_range(NR-1);
      set_addr[i*AW +: AW] = AW'(r);
      if ((!ref_pend[r] || clr[r]) && $urandom_range(1) == 0) set_en[i] = 1'b1;
    end
    src_en = SRC'($urandom);
    src_addr = SRC*AW'($urandom);
    dst_en = 1'($urandom);
    dst_addr = AW'($urandom);
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20211116));
    do_reset();

    // R3: two destinations of one instruction on two set ports.
    set_en = 2'b11; set_addr = {AW'(7), AW'(3)};
    step();
    // R2: both ports name the same register, counted once.
    set_en = 2'b11; set_addr = {AW'(9), AW'(9)};
    step();
    set_en = '0;

    // R9: hazard from source and destination lookups.
    src_en = 3'b010; src_addr = {AW'(1), AW'(7), AW'(2)};
    step();
    src_en = '0; dst_en = 1'b1; dst_addr = AW'(4);
    step();
    dst_en = 1'b0;

    // R4 R10: units 1 and 2 both request port 0; unit 1 wins, unit 2 waits.
    set_slot(1, 0, 1'b1, 7);
    set_slot(2, 0, 1'b1, 9);
    set_slot(0, 1, 1'b1, 3);
    fu_done = 3'b111;
    step();
    step();
    fu_done = '0;

    // R6: a dropped write clears without using a port.
    set_en = 2'b01; set_addr = {AW'(0), AW'(12)};
    step();
    set_en = '0;
    set_slot(0, 1, 1'b0, 12);
    fu_done = 3'b001;
    step();
    fu_done = '0;

    // R7: set and granted write on the same register; set wins.
    set_en = 2'b01; set_addr = {AW'(0), AW'(5)};
    step();
    set_slot(0, 0, 1'b1, 5);
    fu_done = 3'b001;
    set_en = 2'b10; set_addr = {AW'(5), AW'(0)};
    step();
    set_en = '0; fu_done = '0;

    // R8: drop and grant naming one register in one cycle.
    set_en = 2'b01; set_addr = {AW'(0), AW'(6)};
    step();
    set_en = '0;
    set_slot(0, 0, 1'b1, 6);
    set_slot(1, 1, 1'b0, 6);
    fu_done = 3'b011;
    step();
    fu_done = '0;
    set_slot(0, 0, 1'b1, 5);
    fu_done = 3'b001;
    step();
    fu_done = '0;

    // Constrained random: issue, write, drop and set/clear collisions.
    do_reset();
    for (int n = 0; n < 3000; n++) random_cycle();

    // R1: reset in the middle of traffic.
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule